// File: doc/BRIEF.md
# Configurable Synchronous Serial Receiver

This block receives words from a framed synchronous serial link and hands each one over in a 32-bit receive register. A frame sync marks the start of a frame. After a selectable delay of zero, one or two bit clocks the block shifts in data bits. A frame holds one or two phases. Each phase carries its own word count and word length. Words shorter than 32 bits are placed in the register in one of three layouts.

The serial clock, frame sync and data line are ordinary inputs, synchronous to the system clock `clk`. The block detects the selected edge of the serial clock in the `clk` domain, so each serial clock level must last at least one `clk` cycle. A loopback select swaps the external lines for the transmitter's clock, sync and data. A ready flag tells the consumer that a new word is waiting. A one-cycle interrupt pulse marks each new word. A sticky sync-error flag records a frame sync that arrived in the middle of a frame and restarted reception.

Top module: `ssr_rx`

## Requirements
- R1: While `rstN` is low and after it rises, `rxData` is 0 and `rxReady`, `rxIrq` and `rxSyncErr` are all 0.
- R2: The word-length codes on `cfgWdl1`/`cfgWdl2` are 0=8 bits, 1=12, 2=16, 3=20, 4=24, and 5, 6 or 7=32 bits.
- R3: The justification codes on `cfgJustify` are:
  - 0: right-justify with the upper bits zero.
  - 1: right-justify with the upper bits copied from the word's top bit.
  - 2: left-justify with the lower bits zero.
  - 3: same as 0.
- R4: A frame has one phase, or two when `cfgDual`=1.
  - A phase holds the field value plus one words (`cfgLen1`, `cfgLen2`).
  - Words in phase 2 use `cfgWdl2`.
  - Bits after the last word of a frame are ignored until the next frame sync.
- R5: The first data bit is sampled 0, 1 or 2 bit-clock edges after the frame-sync edge, per `cfgDelay`. Code 3 acts as 2, and the data seen during the delay edges is discarded.
- R6: Behaviour of a frame sync that arrives while a frame is in progress:
  - With `cfgFrameIgnore`=1 it is ignored and the current frame continues.
  - With `cfgFrameIgnore`=0 it restarts reception at that edge and sets `rxSyncErr`.
  - `rxSyncErr` stays set until a `rdStrobe` cycle.
- R7: Data and sync are sampled on the rising serial clock edge when `cfgClkRise`=1 and on the falling edge when it is 0. The frame sync is active low when `cfgFsActLow`=1.
- R8: With `cfgLoopback`=1, clock, sync and data come from `lbClk`, `lbFs` and `lbData`, and activity on the external serial lines has no effect.
- R9: Bit order and reversal:
  - With `cfgReverse`=1 and a 32-bit word, the first bit received lands in bit 0 (LSB first).
  - At other word lengths `cfgReverse` has no effect.
  - Without reversal the first bit received is the word's MSB.
- R10: Ready and interrupt behaviour:
  - Each completed word sets `rxReady` and pulses `rxIrq` high for exactly one cycle.
  - A cycle with `rdStrobe` high clears `rxReady` on the next edge, unless a new word completes in that cycle.
- R11: `rxData` changes only on the cycle in which a word completes.
- R12: `rxData` and `rxReady` update on the first `clk` edge that sees the sampling edge of a word's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoopback | input | 1 | Take clock, sync and data from the loopback lines |
| serClk | input | 1 | External serial bit clock |
| serFs | input | 1 | External frame sync |
| serData | input | 1 | External serial data |
| lbClk | input | 1 | Transmitter bit clock for loopback |
| lbFs | input | 1 | Transmitter frame sync for loopback |
| lbData | input | 1 | Transmitter data for loopback |
| cfgDual | input | 1 | Two-phase frame |
| cfgLen1 | input | LEN_W | Phase 1 words minus one |
| cfgLen2 | input | LEN_W | Phase 2 words minus one |
| cfgWdl1 | input | 3 | Phase 1 word-length code |
| cfgWdl2 | input | 3 | Phase 2 word-length code |
| cfgDelay | input | 2 | Data delay in bit clocks |
| cfgFrameIgnore | input | 1 | Ignore frame syncs inside a frame |
| cfgJustify | input | 2 | Justification code |
| cfgReverse | input | 1 | LSB-first assembly of 32-bit words |
| cfgClkRise | input | 1 | Sample on the rising serial clock edge |
| cfgFsActLow | input | 1 | Frame sync active low |
| rdStrobe | input | 1 | Read of the receive register |
| rxData | output | 32 | Receive register |
| rxReady | output | 1 | Unread word present |
| rxIrq | output | 1 | One-cycle pulse per received word |
| rxSyncErr | output | 1 | Sticky unexpected-sync flag |

## Verification
The assertions assume that every serial input is synchronous to `clk` and that each serial clock level lasts at least one cycle. Under that assumption a word needs several cycles, so two completions are never adjacent. The sync-error assertion also assumes that the frame-ignore setting is not changed on the same edge that sees a frame sync. The stimulus holds every serial clock level for two cycles and drives all lines on the falling `clk` edge. It changes the configuration only between frames, while the lines are idle.

// File: rtl/ssr_rx_pkg.sv
package ssr_rx_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {
    JUST_RZERO = 2'd0,
    JUST_RSIGN = 2'd1,
    JUST_LZERO = 2'd2,
    JUST_ALT   = 2'd3
  } justify_e;

  // strobes from control to datapath, valid in one cycle only
  typedef struct packed {
    logic             shiftEn;
    logic             xferEn;
    logic             setErr;
    logic [CNT_W-1:0] wordBits;
  } rx_strobe_t;

  function automatic logic [CNT_W-1:0] wordBitsOf(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(12);
      3'd2:    return CNT_W'(16);
      3'd3:    return CNT_W'(20);
      3'd4:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/ssr_rx_ctrl.sv
module ssr_rx_ctrl
  import ssr_rx_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selClk,
  input  logic             selFs,
  input  logic             cfgDual,
  input  logic [LEN_W-1:0] cfgLen1,
  input  logic [LEN_W-1:0] cfgLen2,
  input  logic [2:0]       cfgWdl1,
  input  logic [2:0]       cfgWdl2,
  input  logic [1:0]       cfgDelay,
  input  logic             cfgFrameIgnore,
  input  logic             cfgClkRise,
  input  logic             cfgFsActLow,
  output rx_strobe_t       strb
);

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_SHIFT} rx_state_e;

  rx_state_e        state, stateNx;
  logic [1:0]       dCnt, dCntNx;
  logic [CNT_W-1:0] bitCnt, bitCntNx;
  logic [LEN_W-1:0] wordCnt, wordCntNx;
  logic             inPh2, inPh2Nx;
  logic             clkQ, fsPrev;

  logic             sampleEdge, fsAct, fsStart, restart;
  logic [CNT_W-1:0] curBits;
  logic [LEN_W-1:0] curLen;

  // edge of the serial clock seen in the clk domain
  assign sampleEdge = cfgClkRise ? (selClk & ~clkQ) : (~selClk & clkQ);
  assign fsAct      = selFs ^ cfgFsActLow;
  assign fsStart    = sampleEdge & fsAct & ~fsPrev;
  assign restart    = fsStart & ((state == S_IDLE) | ~cfgFrameIgnore);

  assign curBits = wordBitsOf(inPh2 ? cfgWdl2 : cfgWdl1);
  assign curLen  = inPh2 ? cfgLen2 : cfgLen1;

  always_comb begin
    stateNx       = state;
    dCntNx        = dCnt;
    bitCntNx      = bitCnt;
    wordCntNx     = wordCnt;
    inPh2Nx       = inPh2;
    strb          = '0;
    strb.wordBits = curBits;
    if (restart) begin
      strb.setErr   = (state != S_IDLE);
      strb.wordBits = wordBitsOf(cfgWdl1);
      inPh2Nx       = 1'b0;
      wordCntNx     = '0;
      if (cfgDelay == 2'd0) begin
        stateNx      = S_SHIFT;
        bitCntNx     = CNT_W'(1);
        strb.shiftEn = 1'b1;
      end else begin
        stateNx = S_DELAY;
        dCntNx  = (cfgDelay == 2'd3) ? 2'd2 : cfgDelay;
      end
    end else if (sampleEdge) begin
      case (state)
        S_DELAY: begin
          if (dCnt == 2'd1) begin
            stateNx      = S_SHIFT;
            bitCntNx     = CNT_W'(1);
            strb.shiftEn = 1'b1;
          end else begin
            dCntNx = dCnt - 2'd1;
          end
        end
        S_SHIFT: begin
          strb.shiftEn = 1'b1;
          if (bitCnt == curBits - CNT_W'(1)) begin
            strb.xferEn = 1'b1;
            bitCntNx    = '0;
            if (wordCnt == curLen) begin
              if (!inPh2 && cfgDual) begin
                inPh2Nx   = 1'b1;
                wordCntNx = '0;
              end else begin
                stateNx = S_IDLE;
              end
            end else begin
              wordCntNx = wordCnt + LEN_W'(1);
            end
          end else begin
            bitCntNx = bitCnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      dCnt    <= '0;
      bitCnt  <= '0;
      wordCnt <= '0;
      inPh2   <= 1'b0;
      clkQ    <= 1'b0;
      fsPrev  <= 1'b0;
    end else begin
      state   <= stateNx;
      dCnt    <= dCntNx;
      bitCnt  <= bitCntNx;
      wordCnt <= wordCntNx;
      inPh2   <= inPh2Nx;
      clkQ    <= selClk;
      if (sampleEdge) fsPrev <= fsAct;
    end
  end

endmodule

// File: rtl/ssr_rx_just.sv
module ssr_rx_just
  import ssr_rx_pkg::*;
(
  input  logic [WORD_W-1:0] rawWord,
  input  logic [CNT_W-1:0]  wordBits,
  input  logic [1:0]        cfgJustify,
  output logic [WORD_W-1:0] outWord
);

  logic [WORD_W-1:0] lowMask, topMask;
  logic [CNT_W-1:0]  padBits;
  logic              signBit;

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign lowMask[i] = (CNT_W'(i) < wordBits);
  end

  assign topMask = lowMask & ~(lowMask >> 1);
  assign signBit = |(rawWord & topMask);
  assign padBits = CNT_W'(WORD_W) - wordBits;

  always_comb begin
    case (justify_e'(cfgJustify))
      JUST_RSIGN: outWord = signBit ? (rawWord | ~lowMask) : (rawWord & lowMask);
      JUST_LZERO: outWord = rawWord << padBits;
      default:    outWord = rawWord & lowMask;
    endcase
  end

endmodule

// File: rtl/ssr_rx_dp.sv
module ssr_rx_dp
  import ssr_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  rx_strobe_t        strb,
  input  logic [1:0]        cfgJustify,
  input  logic              cfgReverse,
  input  logic              rdStrobe,
  output logic [WORD_W-1:0] rxData,
  output logic              rxReady,
  output logic              rxIrq,
  output logic              rxSyncErr
);

  logic [WORD_W-1:0] shReg, shNext, justWord;
  logic              revMode;

  assign revMode = cfgReverse && (strb.wordBits == CNT_W'(WORD_W));
  assign shNext  = revMode ? {bitIn, shReg[WORD_W-1:1]} : {shReg[WORD_W-2:0], bitIn};

  ssr_rx_just u_just (
    .rawWord    (shNext),
    .wordBits   (strb.wordBits),
    .cfgJustify (cfgJustify),
    .outWord    (justWord)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      rxData    <= '0;
      rxReady   <= 1'b0;
      rxIrq     <= 1'b0;
      rxSyncErr <= 1'b0;
    end else begin
      if (strb.shiftEn) shReg <= shNext;
      if (strb.xferEn) begin
        rxData  <= justWord;
        rxReady <= 1'b1;
      end else if (rdStrobe) begin
        rxReady <= 1'b0;
      end
      rxIrq <= strb.xferEn;
      if (strb.setErr)   rxSyncErr <= 1'b1;
      else if (rdStrobe) rxSyncErr <= 1'b0;
    end
  end

endmodule

// File: rtl/ssr_rx.sv
module ssr_rx
  import ssr_rx_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoopback,
  input  logic              serClk,
  input  logic              serFs,
  input  logic              serData,
  input  logic              lbClk,
  input  logic              lbFs,
  input  logic              lbData,
  input  logic              cfgDual,
  input  logic [LEN_W-1:0]  cfgLen1,
  input  logic [LEN_W-1:0]  cfgLen2,
  input  logic [2:0]        cfgWdl1,
  input  logic [2:0]        cfgWdl2,
  input  logic [1:0]        cfgDelay,
  input  logic              cfgFrameIgnore,
  input  logic [1:0]        cfgJustify,
  input  logic              cfgReverse,
  input  logic              cfgClkRise,
  input  logic              cfgFsActLow,
  input  logic              rdStrobe,
  output logic [WORD_W-1:0] rxData,
  output logic              rxReady,
  output logic              rxIrq,
  output logic              rxSyncErr
);

  logic       selClk, selFs, selData;
  rx_strobe_t strb;

  assign selClk  = cfgLoopback ? lbClk  : serClk;
  assign selFs   = cfgLoopback ? lbFs   : serFs;
  assign selData = cfgLoopback ? lbData : serData;

  ssr_rx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .selClk         (selClk),
    .selFs          (selFs),
    .cfgDual        (cfgDual),
    .cfgLen1        (cfgLen1),
    .cfgLen2        (cfgLen2),
    .cfgWdl1        (cfgWdl1),
    .cfgWdl2        (cfgWdl2),
    .cfgDelay       (cfgDelay),
    .cfgFrameIgnore (cfgFrameIgnore),
    .cfgClkRise     (cfgClkRise),
    .cfgFsActLow    (cfgFsActLow),
    .strb           (strb)
  );

  ssr_rx_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .bitIn      (selData),
    .strb       (strb),
    .cfgJustify (cfgJustify),
    .cfgReverse (cfgReverse),
    .rdStrobe   (rdStrobe),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .rxIrq      (rxIrq),
    .rxSyncErr  (rxSyncErr)
  );

endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rdStrobe,
  input logic        cfgFrameIgnore,
  input logic [31:0] rxData,
  input logic        rxReady,
  input logic        rxIrq,
  input logic        rxSyncErr
);

  p_irq_sets_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxReady);

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  p_ready_rise_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> rxIrq);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> (!rxReady || rxIrq));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxIrq |-> $stable(rxData));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxSyncErr && !rdStrobe) |=> rxSyncErr);

  p_ignore_no_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFrameIgnore && !rxSyncErr) |=> !rxSyncErr);

endmodule

bind ssr_rx ssr_rx_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .rdStrobe       (rdStrobe),
  .cfgFrameIgnore (cfgFrameIgnore),
  .rxData         (rxData),
  .rxReady        (rxReady),
  .rxIrq          (rxIrq),
  .rxSyncErr      (rxSyncErr)
);

// File: tb/ssr_rx_bench.sv
module ssr_rx_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoopback, serClk, serFs, serData, lbClk, lbFs, lbData;
  logic cfgDual, cfgFrameIgnore, cfgReverse, cfgClkRise, cfgFsActLow, rdStrobe;
  logic [6:0] cfgLen1, cfgLen2;
  logic [2:0] cfgWdl1, cfgWdl2;
  logic [1:0] cfgDelay, cfgJustify;
  logic [31:0] rxData;
  logic rxReady, rxIrq, rxSyncErr;

  int nChecks = 0;
  int nErr = 0;
  logic sFs[$];
  logic sDat[$];
  logic [31:0] cap[$];

  always #4 clk = ~clk;

  ssr_rx u_ssr_rx (
    .clk(clk), .rstN(rstN), .cfgLoopback(cfgLoopback),
    .serClk(serClk), .serFs(serFs), .serData(serData),
    .lbClk(lbClk), .lbFs(lbFs), .lbData(lbData),
    .cfgDual(cfgDual), .cfgLen1(cfgLen1), .cfgLen2(cfgLen2),
    .cfgWdl1(cfgWdl1), .cfgWdl2(cfgWdl2), .cfgDelay(cfgDelay),
    .cfgFrameIgnore(cfgFrameIgnore), .cfgJustify(cfgJustify),
    .cfgReverse(cfgReverse), .cfgClkRise(cfgClkRise), .cfgFsActLow(cfgFsActLow),
    .rdStrobe(rdStrobe), .rxData(rxData), .rxReady(rxReady),
    .rxIrq(rxIrq), .rxSyncErr(rxSyncErr)
  );

  always @(negedge clk) if (rstN && rxIrq) cap.push_back(rxData);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    cfgLoopback = 1'b0; cfgDual = 1'b0; cfgLen1 = 7'd0; cfgLen2 = 7'd0;
    cfgWdl1 = 3'd2; cfgWdl2 = 3'd0; cfgDelay = 2'd0; cfgFrameIgnore = 1'b1;
    cfgJustify = 2'd0; cfgReverse = 1'b0; cfgClkRise = 1'b1; cfgFsActLow = 1'b0;
  endtask

  task automatic edgeOut(input logic f, input logic d);
    logic act;
    logic fl;
    act = cfgClkRise;
    fl = f ^ cfgFsActLow;
    if (cfgLoopback) begin
      lbClk = ~act; lbFs = fl; lbData = d;
      serClk = ~serClk; serFs = cfgFsActLow; serData = ~d;
    end else begin
      serClk = ~act; serFs = fl; serData = d;
    end
    repeat (2) @(negedge clk);
    if (cfgLoopback) begin
      lbClk = act; serClk = ~serClk;
    end else begin
      serClk = act;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pushWord(input logic [31:0] v, input int n, input bit lsbFirst);
    for (int i = 0; i < n; i++) begin
      sFs.push_back(1'b0);
      sDat.push_back(lsbFirst ? v[i] : v[n-1-i]);
    end
  endtask

  task automatic pushDelay(input int d);
    for (int i = 0; i < d; i++) begin
      sFs.push_back(1'b0);
      sDat.push_back(1'b1);
    end
  endtask

  task automatic play(input int tail);
    foreach (sFs[i]) edgeOut(sFs[i], sDat[i]);
    for (int i = 0; i < tail; i++) edgeOut(1'b0, 1'b0);
    sFs.delete();
    sDat.delete();
  endtask

  task automatic readPulse();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic sendCheck(input string tag, input logic [31:0] v, input int n,
                           input int d, input bit lsbFirst, input logic [31:0] exp);
    int idx;
    cap.delete();
    idx = sFs.size();
    pushDelay(d);
    pushWord(v, n, lsbFirst);
    sFs[idx] = 1'b1;
    play(2);
    check(tag, 32'(cap.size()), 32'd1);
    if (cap.size() > 0) check(tag, cap[0], exp);
  endtask

  task automatic testReset();
    check("R1 data", rxData, 32'h0);
    check("R1 ready", {31'd0, rxReady}, 32'd0);
    check("R1 irq", {31'd0, rxIrq}, 32'd0);
    check("R1 err", {31'd0, rxSyncErr}, 32'd0);
  endtask

  task automatic testLoopback();
    defaults();
    cfgLoopback = 1'b1;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = 16'(k * 16'h1357 + 16'h0246);
      sendCheck("R8 loopback word", {16'd0, v}, 16, 0, 1'b0, {16'd0, v});
      check("R10 ready set", {31'd0, rxReady}, 32'd1);
      check("R8 read back", rxData, {16'd0, v});
      readPulse();
      check("R10 ready cleared", {31'd0, rxReady}, 32'd0);
    end
    defaults();
  endtask

  task automatic testJustify();
    defaults();
    cfgWdl1 = 3'd1;
    cfgJustify = 2'd0; sendCheck("R3 12b rzero", 32'h8A5, 12, 0, 1'b0, 32'h0000_08A5);
    cfgJustify = 2'd1; sendCheck("R3 12b rsign", 32'h8A5, 12, 0, 1'b0, 32'hFFFF_F8A5);
    cfgJustify = 2'd2; sendCheck("R3 12b left", 32'h8A5, 12, 0, 1'b0, 32'h8A50_0000);
    cfgJustify = 2'd3; sendCheck("R3 12b code3", 32'h8A5, 12, 0, 1'b0, 32'h0000_08A5);
    cfgJustify = 2'd1; sendCheck("R3 12b rsign pos", 32'h3A5, 12, 0, 1'b0, 32'h0000_03A5);
    cfgWdl1 = 3'd2;
    cfgJustify = 2'd0; sendCheck("R3 16b rzero", 32'hC3F0, 16, 0, 1'b0, 32'h0000_C3F0);
    cfgJustify = 2'd1; sendCheck("R3 16b rsign", 32'hC3F0, 16, 0, 1'b0, 32'hFFFF_C3F0);
    cfgJustify = 2'd2; sendCheck("R3 16b left", 32'hC3F0, 16, 0, 1'b0, 32'hC3F0_0000);
    defaults();
  endtask

  task automatic testLengths();
    defaults();
    cfgWdl1 = 3'd0; cfgJustify = 2'd1;
    sendCheck("R2 8b", 32'hA7, 8, 0, 1'b0, 32'hFFFF_FFA7);
    cfgWdl1 = 3'd3; cfgJustify = 2'd2;
    sendCheck("R2 20b", 32'h9ABCD, 20, 0, 1'b0, 32'h9ABC_D000);
    cfgWdl1 = 3'd4; cfgJustify = 2'd0;
    sendCheck("R2 24b", 32'h812345, 24, 0, 1'b0, 32'h0081_2345);
    cfgWdl1 = 3'd5;
    sendCheck("R2 R11 32b msb first", 32'hDEAD_BEEF, 32, 0, 1'b0, 32'hDEAD_BEEF);
    cfgWdl1 = 3'd6;
    sendCheck("R2 code6", 32'hCAFE_F00D, 32, 0, 1'b0, 32'hCAFE_F00D);
    defaults();
  endtask

  task automatic testPhases();
    int idx;
    defaults();
    cfgDual = 1'b1; cfgLen1 = 7'd1; cfgWdl1 = 3'd0; cfgLen2 = 7'd0; cfgWdl2 = 3'd1;
    cap.delete();
    idx = sFs.size();
    pushWord(32'h11, 8, 1'b0);
    pushWord(32'h22, 8, 1'b0);
    pushWord(32'hABC, 12, 1'b0);
    sFs[idx] = 1'b1;
    play(2);
    check("R4 dual count", 32'(cap.size()), 32'd3);
    if (cap.size() == 3) begin
      check("R4 dual w0", cap[0], 32'h11);
      check("R4 dual w1", cap[1], 32'h22);
      check("R4 dual phase2 12b", cap[2], 32'hABC);
    end
    cfgDual = 1'b0; cfgLen1 = 7'd2;
    cap.delete();
    idx = sFs.size();
    pushWord(32'h5A, 8, 1'b0);
    pushWord(32'h6B, 8, 1'b0);
    pushWord(32'h7C, 8, 1'b0);
    pushWord(32'h8D, 8, 1'b0);
    sFs[idx] = 1'b1;
    play(2);
    check("R4 single count, extra word dropped", 32'(cap.size()), 32'd3);
    if (cap.size() == 3) check("R4 single last word", cap[2], 32'h7C);
    defaults();
  endtask

  task automatic testDelay();
    defaults();
    cfgDelay = 2'd1; sendCheck("R5 delay1", 32'h1234, 16, 1, 1'b0, 32'h1234);
    cfgDelay = 2'd2; sendCheck("R5 delay2", 32'h5678, 16, 2, 1'b0, 32'h5678);
    cfgDelay = 2'd3; sendCheck("R5 delay code3", 32'h9ABC, 16, 2, 1'b0, 32'h9ABC);
    defaults();
  endtask

  task automatic buildResyncFrame();
    int idx;
    idx = sFs.size();
    pushWord(32'hA5, 8, 1'b0);
    sFs[idx] = 1'b1;
    idx = sFs.size();
    pushWord(32'h3C96, 16, 1'b0);
    sFs[idx] = 1'b1;
  endtask

  task automatic testResync();
    defaults();
    readPulse();
    cfgFrameIgnore = 1'b1;
    cap.delete();
    buildResyncFrame();
    play(2);
    check("R6 ignore count", 32'(cap.size()), 32'd1);
    if (cap.size() > 0) check("R6 ignore word", cap[0], 32'hA53C);
    check("R6 ignore no err", {31'd0, rxSyncErr}, 32'd0);
    cfgFrameIgnore = 1'b0;
    cap.delete();
    buildResyncFrame();
    play(2);
    check("R6 restart count", 32'(cap.size()), 32'd1);
    if (cap.size() > 0) check("R6 restart word", cap[0], 32'h3C96);
    check("R6 err set", {31'd0, rxSyncErr}, 32'd1);
    repeat (3) @(negedge clk);
    check("R6 err sticky", {31'd0, rxSyncErr}, 32'd1);
    readPulse();
    check("R6 err cleared by read", {31'd0, rxSyncErr}, 32'd0);
    defaults();
  endtask

  task automatic testPolarity();
    defaults();
    cfgClkRise = 1'b0; cfgFsActLow = 1'b1;
    sendCheck("R7 falling edge, low sync", 32'h2B7E, 16, 0, 1'b0, 32'h2B7E);
    cfgClkRise = 1'b1; cfgFsActLow = 1'b1;
    sendCheck("R7 rising edge, low sync", 32'h6D1F, 16, 0, 1'b0, 32'h6D1F);
    defaults();
  endtask

  task automatic testReverse();
    defaults();
    cfgReverse = 1'b1; cfgWdl1 = 3'd5;
    sendCheck("R9 32b lsb first", 32'h1234_ABCD, 32, 0, 1'b1, 32'h1234_ABCD);
    cfgWdl1 = 3'd2;
    sendCheck("R9 16b unaffected", 32'h4321, 16, 0, 1'b0, 32'h4321);
    defaults();
  endtask

  task automatic testTiming();
    int idx;
    logic [15:0] v;
    defaults();
    v = 16'h6A6B;
    readPulse();
    idx = sFs.size();
    pushWord({16'd0, v[15:1], 1'b0} >> 1, 15, 1'b0);
    sFs[idx] = 1'b1;
    play(0);
    serClk = 1'b0; serFs = 1'b0; serData = v[0];
    repeat (2) @(negedge clk);
    check("R12 ready before last edge", {31'd0, rxReady}, 32'd0);
    serClk = 1'b1;
    @(negedge clk);
    check("R12 ready one cycle after edge", {31'd0, rxReady}, 32'd1);
    check("R12 data one cycle after edge", rxData, {16'd0, v});
    check("R10 irq pulse", {31'd0, rxIrq}, 32'd1);
    @(negedge clk);
    check("R10 irq single cycle", {31'd0, rxIrq}, 32'd0);
    repeat (2) @(negedge clk);
    defaults();
  endtask

  initial begin
    defaults();
    serClk = 1'b0; serFs = 1'b0; serData = 1'b0;
    lbClk = 1'b0; lbFs = 1'b0; lbData = 1'b0;
    rdStrobe = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoopback();
    testJustify();
    testLengths();
    testPhases();
    testDelay();
    testResync();
    testPolarity();
    testReverse();
    testTiming();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule